// File: doc/BRIEF.md
# Horizon-Based Flow Control Generator

An output link keeps, for each of its H data channels, a scheduling horizon: the latest time at which that channel is already booked. This block watches those horizons and works out the earliest future time at which a chosen number of channels, k, will all be free. That time goes to every upstream neighbour as a send permission: a neighbour may launch new bursts from that time on, and never before it. The result is a time value, not an on/off credit. It is the k-th smallest horizon, and it is never earlier than the current time.

The scheduler may rewrite any horizon on any cycle. The block samples the whole horizon vector, the threshold and the current time on every clock edge. Whenever the horizons or the threshold differ from the previous sample, it publishes a new permission time with a one-cycle valid strobe, at a fixed latency. The output is a broadcast with valid only and no ready. Receivers cannot apply back-pressure and must take the value on every strobe. Between strobes the permission time holds its last value. A threshold of zero selects the default count, which equals the number of upstream neighbours, N_UP. A threshold above H is treated as H.

Top module: `fc_horizon_gate`

## Requirements
- R1: While `rst_n` is low, `perm_valid` is 0 and `perm_time` is 0. Both stay that way until the first publication after reset.
- R2: The block publishes if, at a clock edge N, the sampled horizon vector differs from the one sampled at edge N-1, or edge N is the first edge after reset. To publish, `perm_valid` is 1 for exactly the one cycle that follows edge N+2.
- R3: Channel i's horizon is `hz_in[i*TW +: TW]`, an unsigned time. The published value is the k-th smallest of the H horizons sampled at edge N, before the clamp of R6. Equal horizons each count separately.
- R4: A `thr` value of 0 selects k = N_UP (default 4).
- R5: A `thr` value greater than H selects k = H, which is the largest horizon. Values 1 to H select k = `thr`.
- R6: If the selected horizon is below `now` as sampled at edge N+2, the published `perm_time` equals that `now` instead.
- R7: A change of `thr` between edges N-1 and N also causes a publication with the R2 timing, even when no horizon changed.
- R8: While neither the horizons nor `thr` change, `perm_valid` stays 0 and `perm_time` keeps its value. A change of `now` alone does not cause a publication.
- R9: Changes on consecutive edges each produce their own strobe. The strobes come on consecutive cycles and in the same order as the changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| now | input | TW | Current time |
| hz_in | input | H*TW | Per-channel scheduling horizons; channel i in bits i*TW +: TW |
| thr | input | KW | Required idle channel count; 0 selects N_UP |
| perm_time | output | TW | Earliest time upstream may send new bursts |
| perm_valid | output | 1 | One-cycle strobe marking a new `perm_time` |

## Verification
The assertions assume that `hz_in`, `thr` and `now` are known values sampled only at the rising edge. They also assume that reset is held long enough to clear the three pipeline registers. The bench changes inputs only on falling edges and holds reset for several cycles. It keeps `now` constant across each three-cycle publication window, so the clamp it predicts uses the same `now` that the output stage sees. Back-to-back changes are driven on consecutive falling edges, so the stream-order property is exercised with no idle cycles between strobes.

// File: rtl/fcg_pkg.sv
`timescale 1ns/1ps
package fcg_pkg;
  // Maps a raw threshold onto a zero-based rank: 0 -> default, above h -> h.
  function automatic int unsigned pick_rank(input int unsigned t,
                                            input int unsigned nup,
                                            input int unsigned h);
    int unsigned k;
    if (t == 0) k = nup;
    else if (t > h) k = h;
    else k = t;
    if (k == 0) k = 1;
    if (k > h) k = h;
    return k - 1;
  endfunction
endpackage

// File: rtl/fcg_capture.sv
`timescale 1ns/1ps
module fcg_capture #(
  parameter int H    = 8,
  parameter int TW   = 16,
  parameter int KW   = 5,
  parameter int N_UP = 4,
  localparam int IW  = (H > 1) ? $clog2(H) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [H*TW-1:0] hz_in,
  input  logic [KW-1:0]   thr,
  output logic [H*TW-1:0] hz_q,
  output logic [IW-1:0]   idx_q,
  output logic            chg_q
);
  import fcg_pkg::*;

  logic [KW-1:0] thr_q;
  logic          first_q;
  logic [IW-1:0] idx_c;

  always_comb idx_c = IW'(pick_rank(32'(thr), N_UP, H));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hz_q    <= '0;
      thr_q   <= '0;
      idx_q   <= '0;
      chg_q   <= 1'b0;
      first_q <= 1'b1;
    end else begin
      hz_q    <= hz_in;
      thr_q   <= thr;
      idx_q   <= idx_c;
      chg_q   <= first_q | (hz_in != hz_q) | (thr != thr_q);
      first_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fcg_kth_select.sv
`timescale 1ns/1ps
module fcg_kth_select #(
  parameter int H   = 8,
  parameter int TW  = 16,
  localparam int IW = (H > 1) ? $clog2(H) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [H*TW-1:0] hz,
  input  logic [IW-1:0]   idx,
  input  logic            vin,
  output logic [TW-1:0]   sel_q,
  output logic            vout_q
);
  logic [TW-1:0] h [H];
  logic [H-1:0]  hit;
  logic [TW-1:0] sel_c;

  // Each channel computes its stable rank: how many channels sort before it,
  // ties broken by lower channel index. Ranks form a permutation of 0..H-1.
  for (genvar g = 0; g < H; g++) begin : g_rank
    logic [IW-1:0] r;
    assign h[g] = hz[g*TW +: TW];
    always_comb begin
      r = '0;
      for (int j = 0; j < H; j++) begin
        if (j != g) begin
          if ((h[j] < h[g]) || ((h[j] == h[g]) && (j < g)))
            r = r + IW'(1);
        end
      end
    end
    assign hit[g] = (r == idx);
  end

  always_comb begin
    sel_c = '0;
    for (int i = 0; i < H; i++)
      if (hit[i]) sel_c = sel_c | h[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      vout_q <= 1'b0;
    end else begin
      sel_q  <= sel_c;
      vout_q <= vin;
    end
  end
endmodule

// File: rtl/fcg_clamp.sv
`timescale 1ns/1ps
module fcg_clamp #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] sel,
  input  logic          vin,
  input  logic [TW-1:0] now,
  output logic [TW-1:0] perm_time,
  output logic          perm_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perm_time  <= '0;
      perm_valid <= 1'b0;
    end else begin
      perm_valid <= vin;
      if (vin) perm_time <= (sel < now) ? now : sel;
    end
  end
endmodule

// File: rtl/fc_horizon_gate.sv
`timescale 1ns/1ps
module fc_horizon_gate #(
  parameter int H    = 8,
  parameter int TW   = 16,
  parameter int N_UP = 4,
  parameter int KW   = $clog2(H + 1) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TW-1:0]   now,
  input  logic [H*TW-1:0] hz_in,
  input  logic [KW-1:0]   thr,
  output logic [TW-1:0]   perm_time,
  output logic            perm_valid
);
  localparam int IW = (H > 1) ? $clog2(H) : 1;

  logic [H*TW-1:0] hz_s1;
  logic [IW-1:0]   idx_s1;
  logic            v_s1;
  logic [TW-1:0]   sel_s2;
  logic            v_s2;

  fcg_capture #(.H(H), .TW(TW), .KW(KW), .N_UP(N_UP)) u_cap (
    .clk(clk), .rst_n(rst_n), .hz_in(hz_in), .thr(thr),
    .hz_q(hz_s1), .idx_q(idx_s1), .chg_q(v_s1)
  );

  fcg_kth_select #(.H(H), .TW(TW)) u_sel (
    .clk(clk), .rst_n(rst_n), .hz(hz_s1), .idx(idx_s1), .vin(v_s1),
    .sel_q(sel_s2), .vout_q(v_s2)
  );

  fcg_clamp #(.TW(TW)) u_clamp (
    .clk(clk), .rst_n(rst_n), .sel(sel_s2), .vin(v_s2), .now(now),
    .perm_time(perm_time), .perm_valid(perm_valid)
  );
endmodule

// File: rtl/fcg_checker.sv
`timescale 1ns/1ps
module fcg_checker #(
  parameter int H  = 8,
  parameter int TW = 16,
  parameter int KW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [TW-1:0]   now,
  input logic [H*TW-1:0] hz_in,
  input logic [KW-1:0]   thr,
  input logic [TW-1:0]   perm_time,
  input logic            perm_valid
);
  // R6: a published time is never before the time seen by the output stage
  a_r6_not_past: assert property (@(posedge clk) disable iff (!rst_n)
    perm_valid |-> (perm_time >= $past(now)));

  // R2: a horizon change leads to a strobe after the fixed latency
  a_r2_publish_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (hz_in != $past(hz_in)) |-> ##3 perm_valid);

  // R7: a threshold change also republishes
  a_r7_thr_republish: assert property (@(posedge clk) disable iff (!rst_n)
    (thr != $past(thr)) |-> ##3 perm_valid);

  // R8: the permission time only moves together with a strobe
  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (!perm_valid && $past(rst_n)) |-> (perm_time == $past(perm_time)));
endmodule

bind fc_horizon_gate fcg_checker #(.H(H), .TW(TW), .KW(KW)) u_fcg_chk (
  .clk(clk), .rst_n(rst_n), .now(now), .hz_in(hz_in), .thr(thr),
  .perm_time(perm_time), .perm_valid(perm_valid)
);

// File: tb/tb_fc_horizon_gate.sv
`timescale 1ns/1ps
module tb_fc_horizon_gate;
  localparam int H = 8, TW = 16, NUP = 4, KW = $clog2(H + 1) + 1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [TW-1:0]   now;
  logic [H*TW-1:0] hz_in;
  logic [KW-1:0]   thr;
  logic [TW-1:0]   perm_time;
  logic            perm_valid;
  int nvec = 0, nbad = 0;
  logic [TW-1:0] last_exp;

  always #4 clk = ~clk;

  fc_horizon_gate #(.H(H), .TW(TW), .N_UP(NUP), .KW(KW)) dut (
    .clk(clk), .rst_n(rst_n), .now(now), .hz_in(hz_in), .thr(thr),
    .perm_time(perm_time), .perm_valid(perm_valid)
  );

  function automatic logic [TW-1:0] model(input logic [H*TW-1:0] v,
                                          input logic [KW-1:0] t,
                                          input logic [TW-1:0] n);
    logic [TW-1:0] a [H];
    logic [TW-1:0] tmp, r;
    int k;
    for (int i = 0; i < H; i++) a[i] = v[i*TW +: TW];
    for (int i = 0; i < H; i++)
      for (int j = 0; j < H - 1 - i; j++)
        if (a[j] > a[j+1]) begin tmp = a[j]; a[j] = a[j+1]; a[j+1] = tmp; end
    if (t == 0) k = NUP; else if (int'(t) > H) k = H; else k = int'(t);
    r = a[k-1];
    return (r < n) ? n : r;
  endfunction

  task automatic chk(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_hz(input int c0, c1, c2, c3, c4, c5, c6, c7);
    int v [H];
    v = '{c0, c1, c2, c3, c4, c5, c6, c7};
    for (int i = 0; i < H; i++) hz_in[i*TW +: TW] = TW'(v[i]);
  endtask

  // Called right after a falling edge at which new inputs were driven.
  task automatic expect_publish(input string req);
    logic [TW-1:0] e;
    e = model(hz_in, thr, now);
    repeat (2) begin
      @(negedge clk);
      chk({req, " strobe early"}, TW'(perm_valid), '0);
    end
    @(negedge clk);
    chk({req, " strobe"}, TW'(perm_valid), 1);
    chk({req, " time"}, perm_time, e);
    @(negedge clk);
    chk({req, " strobe width"}, TW'(perm_valid), '0);
    last_exp = e;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; now = '0; thr = '0; hz_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", TW'(perm_valid), '0);
    chk("R1 time in reset", perm_time, '0);
    rst_n = 1'b1;
    expect_publish("R2 first after reset");
  endtask

  task automatic t_default;
    now = 16'd5; thr = '0;
    set_hz(30, 10, 50, 20, 70, 40, 60, 80);
    expect_publish("R4 default k");
    chk("R3 R4 value 40", last_exp, 16'd40);
  endtask

  task automatic t_thr_change;
    thr = KW'(2);
    expect_publish("R7 thr only");
    chk("R7 value 20", last_exp, 16'd20);
  endtask

  task automatic t_ties;
    thr = KW'(3);
    set_hz(15, 15, 15, 9, 9, 100, 200, 15);
    expect_publish("R3 ties");
    thr = KW'(6);
    expect_publish("R3 ties k6");
  endtask

  task automatic t_saturate;
    thr = KW'(31);
    expect_publish("R5 thr 31");
    chk("R5 largest", last_exp, 16'd200);
    thr = KW'(H);
    set_hz(1, 2, 3, 4, 5, 6, 7, 500);
    expect_publish("R5 thr H");
  endtask

  task automatic t_clamp;
    thr = KW'(2); now = 16'd1000;
    set_hz(900, 950, 1200, 1300, 999, 2000, 2100, 2200);
    expect_publish("R6 clamp");
    chk("R6 now", last_exp, 16'd1000);
    set_hz(900, 1001, 1200, 1300, 999, 2000, 2100, 2200);
    expect_publish("R6 edge above now");
  endtask

  task automatic t_quiet;
    now = 16'd1500;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R8 no strobe", TW'(perm_valid), '0);
      chk("R8 hold", perm_time, last_exp);
    end
    now = 16'd1000;
    @(negedge clk);
  endtask

  task automatic t_single_ch;
    thr = KW'(2);
    hz_in[7*TW +: TW] = 16'd950;
    expect_publish("R2 one channel");
  endtask

  task automatic t_back2back;
    logic [TW-1:0] e [3];
    thr = KW'(1);
    set_hz(1100, 1200, 1300, 1400, 1500, 1600, 1700, 1800);
    e[0] = model(hz_in, thr, now);
    @(negedge clk);
    hz_in[0*TW +: TW] = 16'd1900;
    e[1] = model(hz_in, thr, now);
    @(negedge clk);
    thr = KW'(3);
    e[2] = model(hz_in, thr, now);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk("R9 stream strobe", TW'(perm_valid), 1);
      chk("R9 stream order", perm_time, e[i]);
      @(negedge clk);
    end
    chk("R9 stream end", TW'(perm_valid), '0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_default();
    t_thr_change();
    t_ties();
    t_saturate();
    t_clamp();
    t_quiet();
    t_single_ch();
    t_back2back();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule